// File: doc/BRIEF.md
# Masked Vector Even-Lane Duplicator

This block is a single-cycle SIMD data mover. It takes a source vector of up to sixteen 32-bit lanes. For every pair of lanes it copies the lower (even) lane of the source into both lanes of the result. It also takes the current contents of the destination register, so that lanes or upper bits that must be preserved can be passed through. The lane contents are treated as raw bits. No floating-point interpretation takes place, and no floating-point exception can arise.

Three operating styles are selected by a mode input. The legacy style works on 128 bits and leaves the rest of the destination untouched. The plain extended style works on 128 or 256 bits and clears everything above. The masked style works on 128, 256 or 512 bits and applies a per-lane write mask, either merging with or zeroing the unselected lanes, then clears everything above. A 4-bit operand field must be all ones. That field, and any illegal combination of mode and length, produces a fault, and a faulted operation leaves the destination value unchanged.

A request is accepted when `in_valid` is high. The registered result and its fault flag appear with `out_valid` on the following clock edge.

Top module: `lane_dup_unit`

## Requirements
- R1: Result lanes 2n and 2n+1 both carry source lane 2n. Source lane 2n+1 never reaches the result.
- R2: `len_code` 0, 1 and 2 select 4, 8 and 16 active lanes respectively. Code 3 is illegal and raises the fault.
- R3: In masked mode (`mode_sel`=2), an active lane whose `wr_mask` bit is 1 takes its duplicated value. Mask bits at or above the active lane count have no effect on the result.
- R4: In masked mode, an active lane whose mask bit is 0 keeps its `old_dst` value when `zero_fill`=0, and becomes zero when `zero_fill`=1.
- R5: In legacy mode (`mode_sel`=0, `len_code`=0), result bits 511:128 equal `old_dst` bits 511:128.
- R6: In plain extended mode (`mode_sel`=1), result bits at and above the active length (bit 128 or bit 256) are zero, and every active lane takes its duplicated value regardless of `wr_mask`.
- R7: In masked mode, result bits at and above the active length are zero, whatever the mask and `zero_fill` values are.
- R8: A `reg_field` value other than 4'b1111 sets `out_fault`, and the result then equals `old_dst` unchanged.
- R9: An illegal combination of mode and length also sets `out_fault` and returns `old_dst`. The illegal combinations are legacy mode with a non-zero `len_code`, plain mode with `len_code` 2, any use of `mode_sel` 3, and any use of `len_code` 3.
- R10: Lane bit patterns, including NaN and denormal encodings, are copied without change.
- R11: After reset, `out_valid`, `out_fault` and `out_vec` are zero. `out_valid` is high exactly one cycle after an accepted request. Without a request, `out_vec` and `out_fault` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe; inputs are captured when high |
| src_vec | input | 512 | Source vector, 16 lanes of 32 bits |
| old_dst | input | 512 | Current destination contents |
| wr_mask | input | 16 | Per-lane write mask (masked mode only) |
| mode_sel | input | 2 | 0 legacy, 1 plain extended, 2 masked, 3 reserved |
| len_code | input | 2 | 0: 128 bits, 1: 256 bits, 2: 512 bits, 3: illegal |
| zero_fill | input | 1 | Masked mode: 1 zeroes unselected lanes, 0 merges them |
| reg_field | input | 4 | Operand field; must be 4'b1111 |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_vec | output | 512 | Registered result vector |
| out_fault | output | 1 | Undefined-operation fault for the captured request |

## Verification
The bench builds the block with its default parameters: 32-bit lanes and a base group of four lanes. This gives a 512-bit vector with all three lengths legal in masked mode. With these values, every length boundary (bit 128, bit 256 and the full width) can be reached. So can a mask with bits set beyond every active count, and every illegal mode and length pairing.

// File: rtl/lane_dup_pkg.sv
package lane_dup_pkg;

   typedef enum logic [1:0] {
      MODE_LEGACY = 2'd0,
      MODE_PLAIN  = 2'd1,
      MODE_MASKED = 2'd2,
      MODE_RSVD   = 2'd3
   } dup_mode_e;

   localparam int LEN_CODE_W = 2;

endpackage

// File: rtl/lane_dup_spread.sv
module lane_dup_spread #(
   parameter int ELEM_W = 32,
   parameter int ELEMS  = 16,
   localparam int VEC_W  = ELEM_W * ELEMS,
   localparam int PAIRS  = ELEMS / 2
) (
   input  logic [VEC_W-1:0] src,
   output logic [VEC_W-1:0] dup
);

   if ((ELEMS % 2) != 0 || ELEMS < 2) begin : g_bad_elems
      $error("lane_dup_spread: ELEMS must be even and at least 2");
   end

   logic [PAIRS*ELEM_W-1:0] odd_unused;

   for (genvar p = 0; p < PAIRS; p++) begin : g_pair
      assign dup[(2*p)*ELEM_W   +: ELEM_W] = src[(2*p)*ELEM_W +: ELEM_W];
      assign dup[(2*p+1)*ELEM_W +: ELEM_W] = src[(2*p)*ELEM_W +: ELEM_W];
      assign odd_unused[p*ELEM_W +: ELEM_W] = src[(2*p+1)*ELEM_W +: ELEM_W];
   end

endmodule

// File: rtl/lane_dup_legal.sv
module lane_dup_legal
   import lane_dup_pkg::*;
#(
   parameter int FIELD_W = 4
) (
   input  dup_mode_e              mode,
   input  logic [LEN_CODE_W-1:0]  len_code,
   input  logic [FIELD_W-1:0]     field,
   output logic                   fault
);

   if (FIELD_W < 1) begin : g_bad_field
      $error("lane_dup_legal: FIELD_W must be positive");
   end

   logic field_bad;
   logic combo_bad;

   assign field_bad = (field != {FIELD_W{1'b1}});

   always_comb begin
      combo_bad = 1'b0;
      if (len_code == 2'd3) begin
         combo_bad = 1'b1;
      end else begin
         unique case (mode)
            MODE_LEGACY: combo_bad = (len_code != 2'd0);
            MODE_PLAIN:  combo_bad = (len_code == 2'd2);
            MODE_MASKED: combo_bad = 1'b0;
            default:     combo_bad = 1'b1;
         endcase
      end
   end

   assign fault = field_bad | combo_bad;

endmodule

// File: rtl/lane_dup_merge.sv
module lane_dup_merge
   import lane_dup_pkg::*;
#(
   parameter int ELEM_W     = 32,
   parameter int BASE_ELEMS = 4,
   localparam int ELEMS  = BASE_ELEMS * 4,
   localparam int VEC_W  = ELEM_W * ELEMS,
   localparam int CNT_W  = $clog2(ELEMS) + 2
) (
   input  logic [VEC_W-1:0]       dup,
   input  logic [VEC_W-1:0]       old,
   input  logic [ELEMS-1:0]       mask,
   input  dup_mode_e              mode,
   input  logic [LEN_CODE_W-1:0]  len_code,
   input  logic                   zero_fill,
   input  logic                   fault,
   output logic [VEC_W-1:0]       result
);

   logic [CNT_W-1:0] n_active;

   assign n_active = CNT_W'(BASE_ELEMS) << len_code;

   for (genvar i = 0; i < ELEMS; i++) begin : g_lane
      logic              active;
      logic [ELEM_W-1:0] lane_dup;
      logic [ELEM_W-1:0] lane_old;

      assign active   = (CNT_W'(i) < n_active);
      assign lane_dup = dup[i*ELEM_W +: ELEM_W];
      assign lane_old = old[i*ELEM_W +: ELEM_W];

      always_comb begin
         if (fault) begin
            result[i*ELEM_W +: ELEM_W] = lane_old;
         end else if (!active) begin
            result[i*ELEM_W +: ELEM_W] = (mode == MODE_LEGACY) ? lane_old : '0;
         end else if (mode == MODE_MASKED && !mask[i]) begin
            result[i*ELEM_W +: ELEM_W] = zero_fill ? '0 : lane_old;
         end else begin
            result[i*ELEM_W +: ELEM_W] = lane_dup;
         end
      end
   end

endmodule

// File: rtl/lane_dup_unit.sv
module lane_dup_unit
   import lane_dup_pkg::*;
#(
   parameter int ELEM_W     = 32,
   parameter int BASE_ELEMS = 4,
   parameter int FIELD_W    = 4,
   localparam int ELEMS  = BASE_ELEMS * 4,
   localparam int VEC_W  = ELEM_W * ELEMS,
   localparam int BASE_W = ELEM_W * BASE_ELEMS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [VEC_W-1:0]   src_vec,
   input  logic [VEC_W-1:0]   old_dst,
   input  logic [ELEMS-1:0]   wr_mask,
   input  logic [1:0]         mode_sel,
   input  logic [1:0]         len_code,
   input  logic               zero_fill,
   input  logic [FIELD_W-1:0] reg_field,
   output logic               out_valid,
   output logic [VEC_W-1:0]   out_vec,
   output logic               out_fault
);

   if (ELEM_W < 1 || BASE_ELEMS < 2 || (BASE_ELEMS % 2) != 0) begin : g_bad_cfg
      $error("lane_dup_unit: ELEM_W >= 1 and an even BASE_ELEMS >= 2 are required");
   end

   dup_mode_e        mode;
   logic [VEC_W-1:0] dup_vec;
   logic [VEC_W-1:0] next_vec;
   logic             fault_c;

   assign mode = dup_mode_e'(mode_sel);

   lane_dup_spread #(.ELEM_W(ELEM_W), .ELEMS(ELEMS)) u_spread (
      .src (src_vec),
      .dup (dup_vec)
   );

   lane_dup_legal #(.FIELD_W(FIELD_W)) u_legal (
      .mode     (mode),
      .len_code (len_code),
      .field    (reg_field),
      .fault    (fault_c)
   );

   lane_dup_merge #(.ELEM_W(ELEM_W), .BASE_ELEMS(BASE_ELEMS)) u_merge (
      .dup       (dup_vec),
      .old       (old_dst),
      .mask      (wr_mask),
      .mode      (mode),
      .len_code  (len_code),
      .zero_fill (zero_fill),
      .fault     (fault_c),
      .result    (next_vec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_vec   <= '0;
         out_fault <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_vec   <= next_vec;
            out_fault <= fault_c;
         end
      end
   end

   // R11
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R11
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_vec) && $stable(out_fault)));

   // R8
   bad_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && reg_field != {FIELD_W{1'b1}}) |=> out_fault);

   // R8
   fault_keeps_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (!out_fault || out_vec == $past(old_dst)));

   // R5
   legacy_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode_sel == 2'd0 && len_code == 2'd0 && reg_field == {FIELD_W{1'b1}})
      |=> (out_vec[VEC_W-1:BASE_W] == $past(old_dst[VEC_W-1:BASE_W])));

   // R6
   plain_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode_sel == 2'd1 && len_code == 2'd0 && reg_field == {FIELD_W{1'b1}})
      |=> (out_vec[VEC_W-1:BASE_W] == '0));

   // R7
   masked_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode_sel == 2'd2 && len_code == 2'd1 && reg_field == {FIELD_W{1'b1}})
      |=> (out_vec[VEC_W-1:2*BASE_W] == '0));

   // R1
   pair_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode_sel == 2'd1 && len_code == 2'd0 && reg_field == {FIELD_W{1'b1}})
      |=> (out_vec[2*ELEM_W-1:ELEM_W] == $past(src_vec[ELEM_W-1:0])));

endmodule

// File: tb/lane_dup_unit_test.sv
`timescale 1ns/1ps
module lane_dup_unit_test;

   localparam int EW = 32;
   localparam int NE = 16;
   localparam int VW = EW * NE;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [VW-1:0] src_vec = '0;
   logic [VW-1:0] old_dst = '0;
   logic [NE-1:0] wr_mask = '0;
   logic [1:0]    mode_sel = '0;
   logic [1:0]    len_code = '0;
   logic          zero_fill = 1'b0;
   logic [3:0]    reg_field = 4'hF;
   logic          out_valid;
   logic [VW-1:0] out_vec;
   logic          out_fault;

   int vectors = 0;
   int miscompares = 0;
   bit done = 0;

   always #5 clk = ~clk;

   lane_dup_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
      .old_dst(old_dst), .wr_mask(wr_mask), .mode_sel(mode_sel),
      .len_code(len_code), .zero_fill(zero_fill), .reg_field(reg_field),
      .out_valid(out_valid), .out_vec(out_vec), .out_fault(out_fault)
   );

   function automatic logic [VW-1:0] pattern(input logic [15:0] seed);
      logic [VW-1:0] v;
      for (int i = 0; i < NE; i++) v[i*EW +: EW] = {seed, 8'(i), ~8'(i)};
      return v;
   endfunction

   // Reference built from the requirement list
   function automatic logic [VW:0] model(input logic [VW-1:0] s, input logic [VW-1:0] o,
         input logic [NE-1:0] m, input logic [1:0] md, input logic [1:0] ln,
         input logic z, input logic [3:0] f);
      logic [VW-1:0] r;
      logic flt;
      int act;
      flt = (f != 4'hF) || (md == 2'd3) || (ln == 2'd3) ||
            (md == 2'd0 && ln != 2'd0) || (md == 2'd1 && ln == 2'd2);
      act = (ln == 2'd0) ? 4 : (ln == 2'd1) ? 8 : 16;
      if (flt) return {1'b1, o};
      for (int i = 0; i < NE; i++) begin
         if (i >= act) r[i*EW +: EW] = (md == 2'd0) ? o[i*EW +: EW] : '0;
         else if (md == 2'd2 && !m[i]) r[i*EW +: EW] = z ? '0 : o[i*EW +: EW];
         else r[i*EW +: EW] = s[(i - (i % 2))*EW +: EW];
      end
      return {1'b0, r};
   endfunction

   task automatic check(input string req, input logic [VW-1:0] exp_v, input logic exp_f,
                        input logic exp_valid);
      vectors++;
      if (out_vec !== exp_v || out_fault !== exp_f || out_valid !== exp_valid) begin
         miscompares++;
         $display("FAIL %s: vec=%h fault=%b valid=%b expected vec=%h fault=%b valid=%b",
                  req, out_vec, out_fault, out_valid, exp_v, exp_f, exp_valid);
      end
   endtask

   task automatic run(input string req, input logic [VW-1:0] s, input logic [VW-1:0] o,
         input logic [NE-1:0] m, input logic [1:0] md, input logic [1:0] ln,
         input logic z, input logic [3:0] f);
      logic [VW:0] e;
      @(negedge clk);
      src_vec = s; old_dst = o; wr_mask = m; mode_sel = md;
      len_code = ln; zero_fill = z; reg_field = f; in_valid = 1'b1;
      e = model(s, o, m, md, ln, z, f);
      @(negedge clk);
      in_valid = 1'b0;
      check(req, e[VW-1:0], e[VW], 1'b1);
   endtask

   task automatic t_reset();
      check("R11 reset", '0, 1'b0, 1'b0);
   endtask

   task automatic t_legacy();
      run("R5 R1 legacy", pattern(16'h1111), pattern(16'hEEEE), '0, 2'd0, 2'd0, 1'b0, 4'hF);
   endtask

   task automatic t_plain();
      run("R6 plain 128", pattern(16'h2222), pattern(16'hDDDD), '0, 2'd1, 2'd0, 1'b1, 4'hF);
      run("R6 R2 plain 256", pattern(16'h2323), pattern(16'hDCDC), 16'h0000, 2'd1, 2'd1, 1'b0, 4'hF);
   endtask

   task automatic t_masked();
      run("R4 merge 512", pattern(16'h3333), pattern(16'hCCCC), 16'hA5C3, 2'd2, 2'd2, 1'b0, 4'hF);
      run("R4 zero 512", pattern(16'h3434), pattern(16'hCBCB), 16'h5A3C, 2'd2, 2'd2, 1'b1, 4'hF);
      run("R3 R2 full mask 512", pattern(16'h3535), pattern(16'hCACA), 16'hFFFF, 2'd2, 2'd2, 1'b0, 4'hF);
   endtask

   task automatic t_mask_high();
      // R3: bits above the active count make no difference; R7: upper bits zero
      run("R3 R7 high mask bits 128", pattern(16'h4444), pattern(16'hBBBB), 16'hFFF6, 2'd2, 2'd0, 1'b0, 4'hF);
      run("R3 R7 no high mask bits 128", pattern(16'h4444), pattern(16'hBBBB), 16'h0006, 2'd2, 2'd0, 1'b0, 4'hF);
      run("R7 256 zeroing", pattern(16'h4545), pattern(16'hBABA), 16'hF0F0, 2'd2, 2'd1, 1'b1, 4'hF);
   endtask

   task automatic t_bad_field();
      run("R8 field 1110", pattern(16'h5555), pattern(16'hAAAA), 16'hFFFF, 2'd2, 2'd2, 1'b0, 4'hE);
      run("R8 field 0111", pattern(16'h5656), pattern(16'hA9A9), '0, 2'd0, 2'd0, 1'b0, 4'h7);
   endtask

   task automatic t_bad_combo();
      run("R9 legacy 256", pattern(16'h6666), pattern(16'h9999), '0, 2'd0, 2'd1, 1'b0, 4'hF);
      run("R9 plain 512", pattern(16'h6767), pattern(16'h9898), '0, 2'd1, 2'd2, 1'b0, 4'hF);
      run("R9 mode 3", pattern(16'h6868), pattern(16'h9797), '0, 2'd3, 2'd0, 1'b0, 4'hF);
      run("R2 R9 len 3", pattern(16'h6969), pattern(16'h9696), 16'hFFFF, 2'd2, 2'd3, 1'b0, 4'hF);
   endtask

   task automatic t_raw_bits();
      logic [VW-1:0] s;
      s = pattern(16'h7777);
      s[0 +: EW]    = 32'h7FC0_0001;
      s[EW +: EW]   = 32'h1234_5678;
      s[2*EW +: EW] = 32'h0000_0001;
      run("R10 nan denormal", s, '0, 16'hFFFF, 2'd2, 2'd2, 1'b0, 4'hF);
      vectors++;
      if (out_vec[EW +: EW] !== 32'h7FC0_0001 || out_vec[3*EW +: EW] !== 32'h0000_0001) begin
         miscompares++;
         $display("FAIL R10 lanes: lane1=%h lane3=%h expected lane1=7fc00001 lane3=00000001",
                  out_vec[EW +: EW], out_vec[3*EW +: EW]);
      end
   endtask

   task automatic t_hold();
      logic [VW-1:0] last_v;
      logic last_f;
      run("R11 load", pattern(16'h8888), pattern(16'h0101), '0, 2'd1, 2'd0, 1'b0, 4'hF);
      last_v = out_vec;
      last_f = out_fault;
      @(negedge clk);
      src_vec = pattern(16'hFFFF); old_dst = '1; reg_field = 4'h0;
      @(negedge clk);
      check("R11 hold without request", last_v, last_f, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_legacy();
      t_plain();
      t_masked();
      t_mask_high();
      t_bad_field();
      t_bad_combo();
      t_raw_bits();
      t_hold();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         vectors++;
         miscompares++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule